// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host bus of a parallel NOR-style flash and decodes the multi-cycle command protocol. It samples the active-low write strobe with the core clock. When the strobe goes low it captures the address, and when the strobe goes high it takes the data and processes one bus write. Two unlock writes, a command code and the sequence's own later writes are matched against the expected steps. A finished sequence either changes the decoder's operating mode or raises a one-cycle strobe. The strobe comes with the target address, data and bank index captured for that write.

The decoder tracks four modes: normal array reading, the hidden one-time area, an erase in progress, and a suspended erase. Hidden-area programming and hidden-area exit are accepted only while the hidden area is open. Suspend and resume only act on an erase. A write that breaks a sequence aborts it and raises an illegal-command pulse. Downstream program/erase engines use the strobes. The array, its timing and the read path are outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The address (`addr`, `addr_lsb`) is captured in the first clock where `we_n` is seen low after being high. Data is taken in the first clock where `we_n` is seen high after being low. That write's result appears on the outputs from the following clock edge.
- R2: In word mode the unlock pair is AAh written at address 555h, then 55h written at 2AAh. Only address bits 10..0 are compared, and the command write goes to 555h.
- R3: In byte mode the compared value is {addr[10:0], addr_lsb}. The first unlock and the command write use AAAh, and the second unlock uses 555h. `byte_mode` is sampled on the first write of a sequence and held for the rest of it.
- R4: Unlock, A0h, then a write at any address raises `prog_stb` on that fourth write, outside the hidden and erase modes. It presents `cmd_addr` = {addr, addr_lsb}, `cmd_data` = the write data, and `cmd_bank` = addr[21:20]. An A0h command while an erase is running is illegal.
- R5: Unlock then 88h in read mode enters hidden mode. In hidden mode the program sequence raises `hprog_stb` instead of `prog_stb`, but only if the word address is at most 7Fh (byte address at most FFh). Otherwise it is illegal.
- R6: In hidden mode, unlock, 90h, then 00h at any address raises `hexit_stb` and returns to read mode. Both unlock writes and the 90h write must have addr[21:19] = 0. Otherwise the 90h write is illegal, as is 90h outside hidden mode.
- R7: A single F0h write, or unlock followed by F0h, raises `reset_stb` and sets read mode from any mode.
- R8: In read mode, unlock, 80h, unlock, then 30h sets erase mode without a strobe.
- R9: A single B0h write in erase mode raises `susp_stb` and moves to suspended mode. A single 30h write in suspended mode raises `resume_stb` and moves back to erase mode. In any other mode these writes are ignored, with no strobe, no illegal flag and no mode change.
- R10: A write that is not the next expected step raises `illegal` for one cycle, aborts the sequence and leaves the mode unchanged. A later AAh write then starts a fresh sequence.
- R11: Each strobe and `illegal` lasts exactly one cycle, and at most one of them is high at a time.
- R12: After reset the mode is read (encoding read=0, hidden=1, erase=2, suspended=3) and all strobes and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Host write strobe, active low |
| addr | input | 22 | Host word address |
| addr_lsb | input | 1 | Extra low address bit used in byte mode |
| wdata | input | 16 | Host write data; commands use bits 7..0 |
| byte_mode | input | 1 | 1 = byte bus mode, 0 = word bus mode |
| prog_stb | output | 1 | Array program request |
| hprog_stb | output | 1 | Hidden-area program request |
| hexit_stb | output | 1 | Hidden-area exit performed |
| reset_stb | output | 1 | Return-to-read command seen |
| susp_stb | output | 1 | Erase suspend accepted |
| resume_stb | output | 1 | Erase resume accepted |
| illegal | output | 1 | Broken sequence detected |
| cmd_addr | output | 23 | Captured {addr, addr_lsb} of the strobed write |
| cmd_data | output | 16 | Captured data of the strobed write |
| cmd_bank | output | 2 | Bank index addr[21:20] of the strobed write |
| mode | output | 2 | Current mode |

## Verification
The assertions assume that `we_n` stays low for at least one clock and high for at least one clock. This makes each low-then-high pulse a single write. They also assume that no write completes in the first clock after reset. The bench drives each write over whole clock periods. It changes the address to a scrambled value while the strobe is still low, so a wrong capture edge shows up. It holds `byte_mode` valid through each strobe's rising edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_READ   = 2'd0,
        MODE_HIDDEN = 2'd1,
        MODE_ERASE  = 2'd2,
        MODE_ESUSP  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_HEXIT, SQ_ER1, SQ_ER2, SQ_ER3
    } seq_e;

    typedef struct packed {
        logic prog;
        logic hprog;
        logic hexit;
        logic rst;
        logic susp;
        logic resume;
    } strobe_t;

    localparam logic [7:0] CODE_UNL1   = 8'hAA;
    localparam logic [7:0] CODE_UNL2   = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_HENTER = 8'h88;
    localparam logic [7:0] CODE_HEXIT  = 8'h90;
    localparam logic [7:0] CODE_HDONE  = 8'h00;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_SECTOR = 8'h30;
    localparam logic [7:0] CODE_RESET  = 8'hF0;
    localparam logic [7:0] CODE_SUSP   = 8'hB0;
    localparam logic [7:0] CODE_RESUME = 8'h30;

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_lsb,
    output logic              wr_done
);
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic              lsb;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.we = we_n;
        if (cap_q.we && !we_n) begin
            cap_d.addr = addr;
            cap_d.lsb  = addr_lsb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{we: 1'b1, addr: '0, lsb: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign lat_addr = cap_q.addr;
    assign lat_lsb  = cap_q.lsb;
    assign wr_done  = !cap_q.we && we_n;
endmodule

// File: rtl/flash_unlock_match.sv
module flash_unlock_match #(
    parameter int              CMP_W = 11,
    parameter logic [CMP_W-1:0] KEY_A = 11'h555,
    parameter logic [CMP_W-1:0] KEY_B = 11'h2AA
) (
    input  logic [CMP_W-1:0] addr_low,
    input  logic             addr_lsb,
    input  logic             bm,
    output logic             hit_a,
    output logic             hit_b
);
    localparam logic [CMP_W:0] BYTE_A = {KEY_A, 1'b0};
    localparam logic [CMP_W:0] BYTE_B = {KEY_B, 1'b1};

    logic [CMP_W:0] byte_addr;
    assign byte_addr = {addr_low, addr_lsb};

    always_comb begin
        if (bm) begin
            hit_a = (byte_addr == BYTE_A);
            hit_b = (byte_addr == BYTE_B);
        end else begin
            hit_a = (addr_low == KEY_A);
            hit_b = (addr_low == KEY_B);
        end
    end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int HID_W  = 7,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic              lat_lsb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              byte_mode,
    input  logic              hit_a,
    input  logic              hit_b,
    output logic              bm_eff,
    output strobe_t           stb,
    output logic              illegal,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [1:0]        mode
);
    localparam int TOP_W = BANK_W + 1;

    typedef struct packed {
        seq_e              seq;
        mode_e             mode;
        logic              bm;
        logic              bank0;
        strobe_t           stb;
        logic              illegal;
        logic [ADDR_W:0]   caddr;
        logic [DATA_W-1:0] cdata;
        logic [BANK_W-1:0] cbank;
    } fsm_t;

    fsm_t st_d, st_q;
    logic [7:0] code;
    logic       top_zero;
    logic       in_range;
    logic       take;
    logic       bad;

    assign code     = wdata[7:0];
    assign top_zero = (lat_addr[ADDR_W-1 -: TOP_W] == '0);
    assign in_range = (lat_addr[ADDR_W-1:HID_W] == '0);

    always_comb begin
        st_d         = st_q;
        st_d.stb     = '0;
        st_d.illegal = 1'b0;
        take         = 1'b0;
        bad          = 1'b0;
        bm_eff       = (st_q.seq == SQ_IDLE) ? byte_mode : st_q.bm;
        if (wr_done) begin
            st_d.seq = SQ_IDLE;
            case (st_q.seq)
                SQ_IDLE: begin
                    st_d.bm    = byte_mode;
                    st_d.bank0 = top_zero;
                    if (code == CODE_UNL1 && hit_a) begin
                        st_d.seq = SQ_UNL1;
                    end else if (code == CODE_RESET) begin
                        st_d.stb.rst = 1'b1;
                        st_d.mode    = MODE_READ;
                        take         = 1'b1;
                    end else if (code == CODE_SUSP) begin
                        if (st_q.mode == MODE_ERASE) begin
                            st_d.stb.susp = 1'b1;
                            st_d.mode     = MODE_ESUSP;
                            take          = 1'b1;
                        end
                    end else if (code == CODE_RESUME) begin
                        if (st_q.mode == MODE_ESUSP) begin
                            st_d.stb.resume = 1'b1;
                            st_d.mode       = MODE_ERASE;
                            take            = 1'b1;
                        end
                    end else begin
                        bad = 1'b1;
                    end
                end
                SQ_UNL1: begin
                    st_d.bank0 = st_q.bank0 && top_zero;
                    if (code == CODE_UNL2 && hit_b) st_d.seq = SQ_UNL2;
                    else bad = 1'b1;
                end
                SQ_UNL2: begin
                    if (!hit_a) begin
                        bad = 1'b1;
                    end else begin
                        case (code)
                            CODE_PROG: begin
                                if (st_q.mode == MODE_ERASE) bad = 1'b1;
                                else st_d.seq = SQ_PROG;
                            end
                            CODE_HEXIT: begin
                                if (st_q.mode == MODE_HIDDEN && st_q.bank0 && top_zero)
                                    st_d.seq = SQ_HEXIT;
                                else bad = 1'b1;
                            end
                            CODE_HENTER: begin
                                if (st_q.mode == MODE_READ) st_d.mode = MODE_HIDDEN;
                                else bad = 1'b1;
                            end
                            CODE_ERASE: begin
                                if (st_q.mode == MODE_READ) st_d.seq = SQ_ER1;
                                else bad = 1'b1;
                            end
                            CODE_RESET: begin
                                st_d.stb.rst = 1'b1;
                                st_d.mode    = MODE_READ;
                                take         = 1'b1;
                            end
                            default: bad = 1'b1;
                        endcase
                    end
                end
                SQ_PROG: begin
                    if (st_q.mode == MODE_HIDDEN) begin
                        if (in_range) begin
                            st_d.stb.hprog = 1'b1;
                            take           = 1'b1;
                        end else begin
                            bad = 1'b1;
                        end
                    end else begin
                        st_d.stb.prog = 1'b1;
                        take          = 1'b1;
                    end
                end
                SQ_HEXIT: begin
                    if (code == CODE_HDONE) begin
                        st_d.stb.hexit = 1'b1;
                        st_d.mode      = MODE_READ;
                        take           = 1'b1;
                    end else begin
                        bad = 1'b1;
                    end
                end
                SQ_ER1: begin
                    if (code == CODE_UNL1 && hit_a) st_d.seq = SQ_ER2;
                    else bad = 1'b1;
                end
                SQ_ER2: begin
                    if (code == CODE_UNL2 && hit_b) st_d.seq = SQ_ER3;
                    else bad = 1'b1;
                end
                SQ_ER3: begin
                    if (code == CODE_SECTOR) begin
                        st_d.mode = MODE_ERASE;
                        take      = 1'b1;
                    end else begin
                        bad = 1'b1;
                    end
                end
                default: bad = 1'b1;
            endcase
            if (bad) begin
                st_d.illegal = 1'b1;
                st_d.mode    = st_q.mode;
                st_d.seq     = SQ_IDLE;
            end
            if (take) begin
                st_d.caddr = {lat_addr, lat_lsb};
                st_d.cdata = wdata;
                st_d.cbank = lat_addr[ADDR_W-1 -: BANK_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seq: SQ_IDLE, mode: MODE_READ, bm: 1'b0, bank0: 1'b0,
                      stb: '0, illegal: 1'b0, caddr: '0, cdata: '0, cbank: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stb      = st_q.stb;
    assign illegal  = st_q.illegal;
    assign cmd_addr = st_q.caddr;
    assign cmd_data = st_q.cdata;
    assign cmd_bank = st_q.cbank;
    assign mode     = st_q.mode;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11,
    parameter int HID_W  = 7,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              byte_mode,
    output logic              prog_stb,
    output logic              hprog_stb,
    output logic              hexit_stb,
    output logic              reset_stb,
    output logic              susp_stb,
    output logic              resume_stb,
    output logic              illegal,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [1:0]        mode
);
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_lsb;
    logic              wr_done;
    logic              bm_eff;
    logic              hit_a;
    logic              hit_b;
    strobe_t           stb;

    flash_wr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .addr_lsb(addr_lsb),
        .lat_addr(lat_addr), .lat_lsb(lat_lsb), .wr_done(wr_done)
    );

    flash_unlock_match #(.CMP_W(CMP_W)) u_match (
        .addr_low(lat_addr[CMP_W-1:0]), .addr_lsb(lat_lsb), .bm(bm_eff),
        .hit_a(hit_a), .hit_b(hit_b)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HID_W(HID_W), .BANK_W(BANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .lat_addr(lat_addr),
        .lat_lsb(lat_lsb), .wdata(wdata), .byte_mode(byte_mode),
        .hit_a(hit_a), .hit_b(hit_b), .bm_eff(bm_eff), .stb(stb),
        .illegal(illegal), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_bank(cmd_bank), .mode(mode)
    );

    assign prog_stb   = stb.prog;
    assign hprog_stb  = stb.hprog;
    assign hexit_stb  = stb.hexit;
    assign reset_stb  = stb.rst;
    assign susp_stb   = stb.susp;
    assign resume_stb = stb.resume;
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int ADDR_W = 22,
    parameter int HID_W  = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            we_n,
    input logic            prog_stb,
    input logic            hprog_stb,
    input logic            hexit_stb,
    input logic            reset_stb,
    input logic            susp_stb,
    input logic            resume_stb,
    input logic            illegal,
    input logic [ADDR_W:0] cmd_addr,
    input logic [1:0]      mode
);
    logic [6:0] events;
    assign events = {prog_stb, hprog_stb, hexit_stb, reset_stb, susp_stb, resume_stb, illegal};

    // R11: never two events in one cycle
    a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(events));

    // R1: every event follows a low-then-high write strobe
    a_r1_event_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |-> ($past(we_n) && !$past(we_n, 2)));

    // R1: mode only moves after a completed write
    a_r1_mode_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> ($past(we_n) && !$past(we_n, 2)));

    // R5: hidden program only in hidden mode and in range
    a_r5_hprog_window: assert property (@(posedge clk) disable iff (!rst_n)
        hprog_stb |-> (mode == 2'd1 && cmd_addr[ADDR_W:HID_W+1] == '0));

    // R6: exit leaves hidden mode for read mode
    a_r6_exit_mode: assert property (@(posedge clk) disable iff (!rst_n)
        hexit_stb |-> (mode == 2'd0 && $past(mode) == 2'd1));

    // R7: reset always lands in read mode
    a_r7_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
        reset_stb |-> mode == 2'd0);

    // R9: suspend and resume move between erase and suspended
    a_r9_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        susp_stb |-> (mode == 2'd3 && $past(mode) == 2'd2));

    a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |-> (mode == 2'd2 && $past(mode) == 2'd3));

    // R10: an illegal write keeps the mode
    a_r10_illegal_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(mode));

    // R4: plain program never issued while hidden or erasing
    a_r4_prog_mode: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |-> (mode == 2'd0 || mode == 2'd3));
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.ADDR_W(ADDR_W), .HID_W(HID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .prog_stb(prog_stb),
    .hprog_stb(hprog_stb), .hexit_stb(hexit_stb), .reset_stb(reset_stb),
    .susp_stb(susp_stb), .resume_stb(resume_stb), .illegal(illegal),
    .cmd_addr(cmd_addr), .mode(mode)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam logic [6:0] E_NONE = 7'b0000000;
    localparam logic [6:0] E_PROG = 7'b1000000;
    localparam logic [6:0] E_HPRG = 7'b0100000;
    localparam logic [6:0] E_HEXT = 7'b0010000;
    localparam logic [6:0] E_RST  = 7'b0001000;
    localparam logic [6:0] E_SUSP = 7'b0000100;
    localparam logic [6:0] E_RES  = 7'b0000010;
    localparam logic [6:0] E_ILL  = 7'b0000001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1;
    logic [21:0] addr = '0;
    logic        addr_lsb = 1'b0;
    logic [15:0] wdata = '0;
    logic        byte_mode = 1'b0;
    logic        prog_stb, hprog_stb, hexit_stb, reset_stb, susp_stb, resume_stb, illegal;
    logic [22:0] cmd_addr;
    logic [15:0] cmd_data;
    logic [1:0]  cmd_bank;
    logic [1:0]  mode;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .addr_lsb(addr_lsb),
        .wdata(wdata), .byte_mode(byte_mode), .prog_stb(prog_stb),
        .hprog_stb(hprog_stb), .hexit_stb(hexit_stb), .reset_stb(reset_stb),
        .susp_stb(susp_stb), .resume_stb(resume_stb), .illegal(illegal),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_bank(cmd_bank), .mode(mode)
    );

    function automatic logic [6:0] events();
        return {prog_stb, hprog_stb, hexit_stb, reset_stb, susp_stb, resume_stb, illegal};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic [6:0] ev, input logic [1:0] md);
        chk({tag, " events"}, 64'(events()), 64'(ev));
        chk({tag, " mode"}, 64'(mode), 64'(md));
    endtask

    // one bus write; returns at the negedge after the result is registered
    task automatic wr(input logic [21:0] a, input logic l, input logic [7:0] d, input logic bm);
        @(negedge clk);
        addr = a; addr_lsb = l; byte_mode = bm; we_n = 1'b0; wdata = 16'hDEAD;
        @(negedge clk);
        addr = ~a; addr_lsb = ~l; wdata = {8'h00, d}; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr16(input logic [21:0] a, input logic l, input logic [15:0] d, input logic bm);
        @(negedge clk);
        addr = a; addr_lsb = l; byte_mode = bm; we_n = 1'b0; wdata = 16'hBEEF;
        @(negedge clk);
        addr = ~a; addr_lsb = ~l; wdata = d; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock_word(input logic [21:0] hi);
        wr(hi | 22'h555, 1'b0, 8'hAA, 1'b0);
        wr(hi | 22'h2AA, 1'b0, 8'h55, 1'b0);
    endtask

    task automatic t_reset_state();
        expect_out("R12 after reset", E_NONE, 2'd0);
    endtask

    task automatic t_prog_word();
        wr(22'h3F0555, 1'b1, 8'hAA, 1'b0);
        expect_out("R2 unlock1 upper bits ignored", E_NONE, 2'd0);
        wr(22'h2412AA, 1'b0, 8'h55, 1'b0);
        expect_out("R2 unlock2", E_NONE, 2'd0);
        wr(22'h000555, 1'b0, 8'hA0, 1'b0);
        expect_out("R2 command write", E_NONE, 2'd0);
        wr16(22'h2ABCDE, 1'b1, 16'h1234, 1'b0);
        expect_out("R4 program strobe", E_PROG, 2'd0);
        chk("R1 R4 captured address", 64'(cmd_addr), 64'({22'h2ABCDE, 1'b1}));
        chk("R1 R4 captured data", 64'(cmd_data), 64'h1234);
        chk("R4 bank index", 64'(cmd_bank), 64'd2);
        @(negedge clk);
        expect_out("R11 strobe one cycle", E_NONE, 2'd0);
    endtask

    task automatic t_prog_byte();
        wr(22'h000555, 1'b0, 8'hAA, 1'b1);
        wr(22'h0002AA, 1'b1, 8'h55, 1'b0);
        wr(22'h000555, 1'b0, 8'hA0, 1'b0);
        wr16(22'h100100, 1'b0, 16'h00C3, 1'b0);
        expect_out("R3 byte program with held mode", E_PROG, 2'd0);
        chk("R3 bank index", 64'(cmd_bank), 64'd1);
        wr(22'h000555, 1'b0, 8'hAA, 1'b1);
        wr(22'h0002AA, 1'b0, 8'h55, 1'b0);
        expect_out("R3 held byte mode rejects lsb 0", E_ILL, 2'd0);
        wr(22'h000555, 1'b1, 8'hAA, 1'b1);
        expect_out("R3 byte unlock needs lsb 0", E_ILL, 2'd0);
    endtask

    task automatic t_illegal();
        wr(22'h000555, 1'b0, 8'hAA, 1'b0);
        wr(22'h000555, 1'b0, 8'h55, 1'b0);
        expect_out("R10 wrong unlock address", E_ILL, 2'd0);
        @(negedge clk);
        expect_out("R11 illegal one cycle", E_NONE, 2'd0);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h77, 1'b0);
        expect_out("R10 unknown command", E_ILL, 2'd0);
        wr(22'h000555, 1'b0, 8'hA0, 1'b0);
        expect_out("R10 command without unlock", E_ILL, 2'd0);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h90, 1'b0);
        expect_out("R6 exit outside hidden mode", E_ILL, 2'd0);
    endtask

    task automatic t_hidden();
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h88, 1'b0);
        expect_out("R5 hidden entry", E_NONE, 2'd1);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'hA0, 1'b0);
        wr16(22'h00007F, 1'b0, 16'h5A5A, 1'b0);
        expect_out("R5 hidden program top word", E_HPRG, 2'd1);
        chk("R5 hidden program data", 64'(cmd_data), 64'h5A5A);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'hA0, 1'b0);
        wr16(22'h000080, 1'b0, 16'h1111, 1'b0);
        expect_out("R5 hidden program out of range", E_ILL, 2'd1);
        wr(22'h000555, 1'b0, 8'hAA, 1'b1);
        wr(22'h0002AA, 1'b1, 8'h55, 1'b1);
        wr(22'h000555, 1'b0, 8'hA0, 1'b1);
        wr16(22'h00007F, 1'b1, 16'h00EE, 1'b1);
        expect_out("R5 hidden program top byte", E_HPRG, 2'd1);
        chk("R5 hidden byte address", 64'(cmd_addr), 64'h0FF);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h88, 1'b0);
        expect_out("R5 entry while hidden", E_ILL, 2'd1);
    endtask

    task automatic t_hexit();
        unlock_word(22'h080000);
        wr(22'h000555, 1'b0, 8'h90, 1'b0);
        expect_out("R6 nonzero bank address", E_ILL, 2'd1);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h90, 1'b0);
        expect_out("R6 exit command", E_NONE, 2'd1);
        wr(22'h3FFFFF, 1'b1, 8'h00, 1'b0);
        expect_out("R6 exit done", E_HEXT, 2'd0);
    endtask

    task automatic t_reset_cmds();
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h88, 1'b0);
        wr(22'h1234AB, 1'b0, 8'hF0, 1'b0);
        expect_out("R7 single-write reset", E_RST, 2'd0);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h88, 1'b0);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'hF0, 1'b0);
        expect_out("R7 unlocked reset", E_RST, 2'd0);
    endtask

    task automatic t_erase();
        wr(22'h000000, 1'b0, 8'hB0, 1'b0);
        expect_out("R9 suspend ignored in read", E_NONE, 2'd0);
        wr(22'h000000, 1'b0, 8'h30, 1'b0);
        expect_out("R9 resume ignored in read", E_NONE, 2'd0);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'h80, 1'b0);
        unlock_word(22'h0);
        wr(22'h1F0000, 1'b0, 8'h30, 1'b0);
        expect_out("R8 sector erase started", E_NONE, 2'd2);
        wr(22'h000000, 1'b0, 8'h30, 1'b0);
        expect_out("R9 resume ignored in erase", E_NONE, 2'd2);
        wr(22'h000000, 1'b0, 8'hB0, 1'b0);
        expect_out("R9 suspend", E_SUSP, 2'd3);
        wr(22'h000000, 1'b0, 8'hB0, 1'b0);
        expect_out("R9 suspend ignored when suspended", E_NONE, 2'd3);
        wr(22'h000000, 1'b0, 8'h30, 1'b0);
        expect_out("R9 resume", E_RES, 2'd2);
        unlock_word(22'h0);
        wr(22'h000555, 1'b0, 8'hA0, 1'b0);
        expect_out("R4 program during erase", E_ILL, 2'd2);
        wr(22'h000000, 1'b0, 8'hF0, 1'b0);
        expect_out("R7 reset from erase", E_RST, 2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_prog_word();
        t_prog_byte();
        t_illegal();
        t_hidden();
        t_hexit();
        t_reset_cmds();
        t_erase();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule